// File: doc/BRIEF.md
# Periodic Battery-Low Monitor

This block schedules checks of a backup battery and keeps a sticky battery-low flag. Whenever the main supply becomes valid it opens a comparator test window at once. After that, while the supply stays valid, it opens another window each time a long interval expires. The interval is counted in prescaled ticks, so a default build can space tests 24 hours apart while a test build shrinks the spacing to a few dozen clocks.

During a window the comparator strobe is held high for a fixed settle time. The comparator flag is taken only on the last cycle of that window, and the result is written to the battery-low flag. The flag keeps its value until a later completed test writes it again.

When the supply goes invalid, all activity stops. Any open window is abandoned without updating the flag, and the interval count is discarded. The next supply-valid period starts again with a power-up test.

The controller has three named states:
- `BW_OFF`: the supply is invalid.
- `BW_TEST`: a comparator window is open.
- `BW_WAIT`: the block is counting toward the next periodic test.

The transitions are:
- `BW_OFF` to `BW_TEST` when the supply becomes valid (power-up test).
- `BW_TEST` to `BW_WAIT` on the last window cycle (sample taken).
- `BW_WAIT` to `BW_TEST` when the interval expires.
- Any state to `BW_OFF` when the supply is invalid (abandon).

Top module: `battery_watch`

## Requirements
- R1: While reset is asserted, and right after it is released with the supply invalid, `cmp_strobe` is 0 and `batt_low_n` is 1 (battery not flagged low).
- R2: On any clock edge where `supply_ok` is 0, no test runs. After that edge `cmp_strobe` is 0 and `batt_low_n` is unchanged, whatever `batt_below` does.
- R3: The first clock edge that sees `supply_ok` at 1 after it was 0 starts a power-up test. From that edge `cmp_strobe` is 1 for exactly SETTLE cycles.
- R4: `batt_below` (1 = battery below threshold) is used only at the edge that ends a window, meaning the edge after the last strobe-high cycle. Right after that edge, `batt_low_n` becomes the inverse of the sampled value (0 = battery low). Values outside that single cycle have no effect.
- R5: `batt_low_n` changes only at the end of a completed test. A low indication stays until a later test samples `batt_below` at 0.
- R6: After each completed test, including a power-up test, the strobe rises again exactly PRESCALE*INTERVAL cycles after it fell, as long as the supply stays valid.
- R7: If the supply drops while a window is open, the window is abandoned and `batt_low_n` keeps the value it had before the window.
- R8: The interval count does not advance while the supply is invalid. After power returns, the schedule is measured from the new power-up test, not from the old count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Main supply within tolerance (1 = valid) |
| batt_below | input | 1 | Synchronous comparator flag, 1 = battery below threshold |
| cmp_strobe | output | 1 | Enables the battery comparator during a test window |
| batt_low_n | output | 1 | Latched battery-low indication, 0 = low |

## Verification
The bench sweeps every combination of good and low results over four consecutive tests. This exercises set, hold and clear of the sticky flag in every order. A design that cleared the flag without a passing test, or that sampled on the wrong cycle, would show the wrong level on at least one cycle.

Outside the single sampling cycle, the comparator input is driven to the opposite value. A design that sampled early, sampled continuously or sampled between windows would therefore flip the flag.

Each run ends with the supply dropped exactly as a periodic window opens. Odd runs also re-power and drop again inside the power-up window. A design that finished abandoned windows, or that kept its interval count across an outage, would update the flag or misplace the next strobe.

// File: rtl/bw_pkg.sv
package bw_pkg;

    typedef enum logic [1:0] {
        BW_OFF  = 2'd0,
        BW_WAIT = 2'd1,
        BW_TEST = 2'd2
    } bw_state_e;

endpackage

// File: rtl/bw_interval_timer.sv
module bw_interval_timer #(
    parameter int PRESCALE = 32768,
    parameter int INTERVAL = 86400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic due
);
    localparam int IW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [IW-1:0] IVL_LAST = IW'(INTERVAL - 1);

    logic          tick;
    logic [IW-1:0] ivl_cnt;

    generate
        if (PRESCALE > 1) begin : g_prescaler
            localparam int PW = $clog2(PRESCALE);
            localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);
            logic [PW-1:0] pre_cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre_cnt <= '0;
                end else if (!run || pre_cnt == PRE_LAST) begin
                    pre_cnt <= '0;
                end else begin
                    pre_cnt <= pre_cnt + 1'b1;
                end
            end

            assign tick = run && (pre_cnt == PRE_LAST);
        end else begin : g_no_prescaler
            assign tick = run;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ivl_cnt <= '0;
        end else if (!run) begin
            ivl_cnt <= '0;
        end else if (tick) begin
            ivl_cnt <= (ivl_cnt == IVL_LAST) ? '0 : ivl_cnt + 1'b1;
        end
    end

    assign due = tick && (ivl_cnt == IVL_LAST);

    assert_ivl_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ivl_cnt) < INTERVAL);

    assert_frozen_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (ivl_cnt == '0));

endmodule

// File: rtl/bw_settle_window.sv
module bw_settle_window #(
    parameter int SETTLE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int SW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam logic [SW-1:0] WIN_LAST = SW'(SETTLE - 1);

    logic [SW-1:0] win_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt <= '0;
        end else if (!run || win_cnt == WIN_LAST) begin
            win_cnt <= '0;
        end else begin
            win_cnt <= win_cnt + 1'b1;
        end
    end

    assign last = run && (win_cnt == WIN_LAST);

    assert_win_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(win_cnt) < SETTLE);

    assert_win_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (win_cnt == '0));

endmodule

// File: rtl/bw_sequencer.sv
module bw_sequencer
    import bw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic batt_below,
    input  logic ivl_due,
    input  logic win_last,
    output logic in_wait,
    output logic in_test,
    output logic cmp_strobe,
    output logic batt_low_n
);
    bw_state_e state, state_nx;
    logic      low_q;

    always_comb begin
        state_nx = state;
        if (!supply_ok) begin
            state_nx = BW_OFF;
        end else begin
            unique case (state)
                BW_OFF:  state_nx = BW_TEST;
                BW_WAIT: if (ivl_due)  state_nx = BW_TEST;
                BW_TEST: if (win_last) state_nx = BW_WAIT;
                default: state_nx = BW_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= BW_OFF;
            low_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (supply_ok && state == BW_TEST && win_last) begin
                low_q <= batt_below;
            end
        end
    end

    always_comb begin
        in_wait    = (state == BW_WAIT);
        in_test    = (state == BW_TEST);
        cmp_strobe = (state == BW_TEST);
        batt_low_n = ~low_q;
    end

    assert_no_strobe_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !cmp_strobe);

    assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> $stable(low_q));

    assert_update_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(low_q) |-> ($past(cmp_strobe) && $past(win_last)));

    assert_powerup_test_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BW_OFF && supply_ok) |=> cmp_strobe);

endmodule

// File: rtl/battery_watch.sv
module battery_watch #(
    parameter int PRESCALE = 32768,
    parameter int INTERVAL = 86400,
    parameter int SETTLE   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic batt_below,
    output logic cmp_strobe,
    output logic batt_low_n
);
    logic in_wait;
    logic in_test;
    logic ivl_due;
    logic win_last;

    bw_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_ok  (supply_ok),
        .batt_below (batt_below),
        .ivl_due    (ivl_due),
        .win_last   (win_last),
        .in_wait    (in_wait),
        .in_test    (in_test),
        .cmp_strobe (cmp_strobe),
        .batt_low_n (batt_low_n)
    );

    bw_interval_timer #(
        .PRESCALE (PRESCALE),
        .INTERVAL (INTERVAL)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_wait),
        .due   (ivl_due)
    );

    bw_settle_window #(
        .SETTLE (SETTLE)
    ) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_test),
        .last  (win_last)
    );

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!cmp_strobe || rst_n));

endmodule

// File: tb/battery_watch_test.sv
`timescale 1ns/1ps
module battery_watch_test;
    localparam int P = 3;
    localparam int I = 4;
    localparam int S = 2;
    localparam int L = S + P * I;
    localparam int NT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic batt_below = 1'b0;
    logic cmp_strobe;
    logic batt_low_n;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    battery_watch #(.PRESCALE(P), .INTERVAL(I), .SETTLE(S)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_ok  (supply_ok),
        .batt_below (batt_below),
        .cmp_strobe (cmp_strobe),
        .batt_low_n (batt_low_n)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        logic prev_low;
        logic bitv;
        step();
        step();
        // R1: reset state
        chk("R1 strobe in reset", cmp_strobe, 1'b0);
        chk("R1 low_n in reset", batt_low_n, 1'b1);
        rst_n = 1'b1;
        step();
        chk("R1 strobe after reset", cmp_strobe, 1'b0);
        chk("R1 low_n after reset", batt_low_n, 1'b1);
        // R2: supply invalid, comparator toggling, nothing happens
        for (int c = 0; c < 20; c++) begin
            batt_below = c[0];
            step();
            chk("R2 strobe while off", cmp_strobe, 1'b0);
            chk("R2 low_n while off", batt_low_n, 1'b1);
        end
        prev_low = 1'b0;

        for (int pat = 0; pat < (1 << NT); pat++) begin
            // power-up; schedule measured from here (R8)
            supply_ok = 1'b1;
            batt_below = ~pat[0];
            step();
            for (int t = 0; t < NT * L; t++) begin
                logic exp_low;
                bitv = pat[t / L];
                exp_low = (t < S) ? prev_low : pat[(t - S) / L];
                if (t < L)
                    chk("R3 R8 power-up window and schedule", cmp_strobe, (t % L) < S);
                else
                    chk("R6 periodic window", cmp_strobe, (t % L) < S);
                chk("R4 R5 latched level", batt_low_n, ~exp_low);
                batt_below = ((t % L) == S - 1) ? bitv : ~bitv;
            step();
            end
            prev_low = pat[NT - 1];
            // a periodic window opens here
            chk("R6 window after last interval", cmp_strobe, 1'b1);
            chk("R5 level held at window start", batt_low_n, ~prev_low);
            supply_ok = 1'b0;
            batt_below = ~prev_low;
            for (int c = 0; c < 6; c++) begin
                step();
                chk("R7 strobe after drop", cmp_strobe, 1'b0);
                chk("R7 level kept after drop", batt_low_n, ~prev_low);
                batt_below = (c % 2 == 0) ? ~prev_low : prev_low;
            end
            if (pat % 2 == 1) begin
                supply_ok = 1'b1;
                batt_below = ~prev_low;
                step();
                chk("R3 power-up strobe", cmp_strobe, 1'b1);
                supply_ok = 1'b0;
                for (int c = 0; c < 4; c++) begin
                    step();
                    chk("R7 abandoned power-up test", batt_low_n, ~prev_low);
                    chk("R2 no strobe while off", cmp_strobe, 1'b0);
                end
            end
            // long outage: longer than an interval (R8)
            for (int c = 0; c < 2 * L; c++) begin
                batt_below = c[0];
                step();
            end
            chk("R2 level after outage", batt_low_n, ~prev_low);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule